// File: doc/BRIEF.md
# Platform Alert Event Message Generator

This block gathers platform health events and turns them into a status snapshot, a sequence number and a send strobe for a remote management alert message. It watches a chassis intrusion flag, an active-low thermal alarm, a watchdog second-timeout pulse, a software send request, the data returned by the first boot fetch, a general-purpose input level, a processor first-fetch failure flag and the full-on power state indication. It decides when a message goes out and what it carries. The network transport, frame formatting, watchdog counter and boot fetch logic are not part of the block. Each of them appears only as an input.

Six event bits are sticky and are cleared by software through a write-1-to-clear strobe and mask. A seventh bit follows the general-purpose input level live. When a message is issued, the strobe `send_o` rises and holds a frozen copy of the status word and a new sequence number until the transport acknowledges it. The block issues one further alert after the system leaves full-on power. It also refuses to repeat a processor-missing or watchdog alert while the watchdog bit that raised it is still set.

Top module: `alert_msg_gen`

## Requirements
- R1: Status bit layout (live_o and status_o): bit0 intrusion, bit1 thermal, bit2 processor missing, bit3 watchdog timeout, bit4 software request, bit5 unprogrammed firmware, bit6 general-purpose level. Bits 0 to 5 are sticky. A pulse on intrude_i, cpu_fail_i, wdt_to_i or sw_send_i sets its bit. A fetch_vld_i beat whose data is all ones (FFh) sets bit5, and any other data value does not. Each of these set events raises a message trigger.
- R2: Bit1 is set in every cycle in which therm_ni is low. Only a high-to-low transition of therm_ni triggers a message.
- R3: Bit6 equals gpio_i as registered one cycle earlier. Every transition of gpio_i, rising or falling, triggers a message.
- R4: While clr_we_i is high, each sticky bit whose clr_mask_i bit is 1 is cleared. A set event in the same cycle takes priority over the clear. Bit6 cannot be cleared.
- R5: A message is issued in the cycle after its trigger. send_o then stays high, with seq_o and status_o stable, until a cycle in which send_ack_i is high. status_o equals live_o in the cycle of issue.
- R6: seq_o resets to 0 and increases by exactly 1 for each issued message, so the first message carries 1. It wraps modulo 2^SEQ_W.
- R7: Triggers that occur in the same cycle produce a single message.
- R8: Triggers that arrive while send_o waits for acknowledge are merged into one queued message. That message is issued in the same cycle the acknowledge is taken, so send_o stays high.
- R9: While full_on_i is low, only one trigger is accepted. Further triggers are dropped until full_on_i returns high, although their status bits are still set.
- R10: While bit3 is set, wdt_to_i and cpu_fail_i pulses set their bits but raise no trigger.
- R11: After reset, send_o is 0, seq_o is 0, status_o is 0 and live_o is 0, with gpio_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-good reset |
| intrude_i | input | 1 | Chassis intrusion detected pulse |
| therm_ni | input | 1 | Thermal alarm, active low level |
| wdt_to_i | input | 1 | Watchdog second-timeout pulse |
| sw_send_i | input | 1 | Software send-now write pulse |
| fetch_vld_i | input | 1 | First boot fetch data valid |
| fetch_data_i | input | FETCH_W | First boot fetch data |
| cpu_fail_i | input | 1 | Processor failed first fetch pulse |
| gpio_i | input | 1 | General-purpose input level |
| full_on_i | input | 1 | System is in the full-on power state |
| clr_we_i | input | 1 | Write-1-to-clear strobe |
| clr_mask_i | input | 7 | Bits to clear |
| send_ack_i | input | 1 | Transport accepted the message |
| send_o | output | 1 | Message valid, held until acknowledged |
| seq_o | output | SEQ_W | Sequence number of the current message |
| status_o | output | 7 | Status snapshot carried by the message |
| live_o | output | 7 | Current status register |

## Verification
Every result of this block is due exactly one rising edge after its stimulus: the sticky bits, the registered level bit, the issue of a message and the queued re-issue on acknowledge. The bench therefore drives inputs just after a falling edge and advances its behavioural model on the rising edge. It compares all four outputs 2 ns later, so every comparison reads the cycle in which the design's registers have just updated. Directed checks at the following falling edge confirm the expected sequence numbers of each scenario, including a full wrap of the 16-bit counter with the acknowledge held high.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int STAT_W   = 7;
  localparam int STICKY_W = 6;
  localparam int B_TAMPER = 0;
  localparam int B_TEMP   = 1;
  localparam int B_CPU    = 2;
  localparam int B_WDT    = 3;
  localparam int B_SW     = 4;
  localparam int B_UNPROG = 5;
  localparam int B_GPIO   = 6;

  typedef logic [STAT_W-1:0]   stat_t;
  typedef logic [STICKY_W-1:0] sticky_t;
endpackage

// File: rtl/alert_edge_det.sv
module alert_edge_det #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= d_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_o[i] = d_i[i] & ~q_q[i];
    assign fall_o[i] = ~d_i[i] & q_q[i];
  end

  assign q_o = q_q;
endmodule

// File: rtl/alert_sticky.sv
module alert_sticky #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  logic [N-1:0] q_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // set beats clear
    assign nxt_o[i] = set_i[i] | (q_q[i] & ~clr_i[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q[i] <= 1'b0;
      else         q_q[i] <= nxt_o[i];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/alert_sender.sv
module alert_sender
  import alert_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             full_on_i,
  input  logic             ack_i,
  input  stat_t            snap_i,
  output logic             send_o,
  output logic [SEQ_W-1:0] seq_o,
  output stat_t            status_o
);
  logic             send_q, pend_q, off_used_q;
  logic [SEQ_W-1:0] seq_q;
  stat_t            stat_q;
  logic             allow, trig_ok, issue_ok, want;

  assign allow    = full_on_i | ~off_used_q;
  assign trig_ok  = trig_i & allow;
  assign issue_ok = ~send_q | ack_i;
  assign want     = trig_ok | pend_q;

  // one alert budget outside full-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        off_used_q <= 1'b0;
    else if (full_on_i) off_used_q <= 1'b0;
    else if (trig_ok)   off_used_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_q <= 1'b0;
      pend_q <= 1'b0;
      seq_q  <= '0;
      stat_q <= '0;
    end else if (want && issue_ok) begin
      send_q <= 1'b1;
      pend_q <= 1'b0;
      seq_q  <= seq_q + 1'b1;
      stat_q <= snap_i;
    end else begin
      if (trig_ok) pend_q <= 1'b1;
      if (ack_i)   send_q <= 1'b0;
    end
  end

  assign send_o   = send_q;
  assign seq_o    = seq_q;
  assign status_o = stat_q;
endmodule

// File: rtl/alert_msg_gen.sv
module alert_msg_gen
  import alert_pkg::*;
#(
  parameter int SEQ_W   = 16,
  parameter int FETCH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               intrude_i,
  input  logic               therm_ni,
  input  logic               wdt_to_i,
  input  logic               sw_send_i,
  input  logic               fetch_vld_i,
  input  logic [FETCH_W-1:0] fetch_data_i,
  input  logic               cpu_fail_i,
  input  logic               gpio_i,
  input  logic               full_on_i,
  input  logic               clr_we_i,
  input  logic [STAT_W-1:0]  clr_mask_i,
  input  logic               send_ack_i,
  output logic               send_o,
  output logic [SEQ_W-1:0]   seq_o,
  output logic [STAT_W-1:0]  status_o,
  output logic [STAT_W-1:0]  live_o
);
  localparam logic [FETCH_W-1:0] ERASED = '1;
  localparam int LVL_W = 2;
  localparam int L_GPIO = 0;
  localparam int L_THERM = 1;

  logic [LVL_W-1:0] lvl_q, lvl_rise, lvl_fall;
  sticky_t          set_v, clr_v, stk_q, stk_nxt;
  logic             unprog, dup_blk, trig;
  stat_t            snap;

  alert_edge_det #(.W(LVL_W), .RST_VAL(2'b10)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({therm_ni, gpio_i}),
    .q_o    (lvl_q),
    .rise_o (lvl_rise),
    .fall_o (lvl_fall)
  );

  assign unprog = fetch_vld_i & (fetch_data_i == ERASED);

  always_comb begin
    set_v           = '0;
    set_v[B_TAMPER] = intrude_i;
    set_v[B_TEMP]   = ~therm_ni;
    set_v[B_CPU]    = cpu_fail_i;
    set_v[B_WDT]    = wdt_to_i;
    set_v[B_SW]     = sw_send_i;
    set_v[B_UNPROG] = unprog;
  end

  assign clr_v = clr_we_i ? clr_mask_i[STICKY_W-1:0] : '0;

  alert_sticky #(.N(STICKY_W)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (stk_q),
    .nxt_o  (stk_nxt)
  );

  // no repeat of watchdog / missing-cpu alert until watchdog bit cleared
  assign dup_blk = stk_q[B_WDT];

  assign trig = intrude_i | lvl_fall[L_THERM] | lvl_rise[L_GPIO] |
                lvl_fall[L_GPIO] | sw_send_i | unprog |
                ((wdt_to_i | cpu_fail_i) & ~dup_blk);

  assign snap   = {gpio_i, stk_nxt};
  assign live_o = {lvl_q[L_GPIO], stk_q};

  alert_sender #(.SEQ_W(SEQ_W)) u_send (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .full_on_i (full_on_i),
    .ack_i     (send_ack_i),
    .snap_i    (snap),
    .send_o    (send_o),
    .seq_o     (seq_o),
    .status_o  (status_o)
  );
endmodule

// File: rtl/alert_msg_gen_chk.sv
module alert_msg_gen_chk #(
  parameter int SEQ_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             intrude_i,
  input logic             gpio_i,
  input logic             clr_we_i,
  input logic [6:0]       clr_mask_i,
  input logic             send_ack_i,
  input logic             send_o,
  input logic [SEQ_W-1:0] seq_o,
  input logic [6:0]       status_o,
  input logic [6:0]       live_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o && !send_ack_i |=> send_o && $stable(seq_o) && $stable(status_o));

  a_r5_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_o) |-> status_o == live_o);

  a_r6_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (seq_o != $past(seq_o)) |-> seq_o == SEQ_W'($past(seq_o) + 1'b1));

  a_r6_seq_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (seq_o != $past(seq_o)) |-> send_o);

  a_r1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o[0] && !(clr_we_i && clr_mask_i[0]) |=> live_o[0]);

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_mask_i[0] && !intrude_i |=> !live_o[0]);

  a_r3_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> live_o[6] == $past(gpio_i));
endmodule

bind alert_msg_gen alert_msg_gen_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .intrude_i  (intrude_i),
  .gpio_i     (gpio_i),
  .clr_we_i   (clr_we_i),
  .clr_mask_i (clr_mask_i),
  .send_ack_i (send_ack_i),
  .send_o     (send_o),
  .seq_o      (seq_o),
  .status_o   (status_o),
  .live_o     (live_o)
);

// File: tb/sim_alert_msg_gen.sv
`timescale 1ns/1ps
module sim_alert_msg_gen;
  localparam int SEQ_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic intrude = 0, therm_n = 1, wdt = 0, sw = 0, fvld = 0, cpuf = 0, gpio = 0;
  logic full_on = 1, clr_we = 0, ack = 0;
  logic [7:0] fdata = 8'h00;
  logic [6:0] clr_mask = '0;
  logic send;
  logic [SEQ_W-1:0] seq;
  logic [6:0] status, live;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R11";

  always #5 clk = ~clk;

  alert_msg_gen #(.SEQ_W(SEQ_W), .FETCH_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .intrude_i(intrude), .therm_ni(therm_n),
    .wdt_to_i(wdt), .sw_send_i(sw), .fetch_vld_i(fvld), .fetch_data_i(fdata),
    .cpu_fail_i(cpuf), .gpio_i(gpio), .full_on_i(full_on), .clr_we_i(clr_we),
    .clr_mask_i(clr_mask), .send_ack_i(ack), .send_o(send), .seq_o(seq),
    .status_o(status), .live_o(live));

  // behavioural reference model
  bit [5:0] m_stk;
  bit       m_gpio, m_therm, m_send, m_pend, m_off;
  int       m_seq;
  bit [6:0] m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stk = 0; m_gpio = 0; m_therm = 1; m_send = 0; m_pend = 0; m_off = 0;
      m_seq = 0; m_stat = 0;
    end else begin
      bit [5:0] nstk;
      bit raw, ok, go;
      raw = intrude || (m_therm && !therm_n) || (gpio != m_gpio) || sw ||
            (fvld && fdata == 8'hFF) || ((wdt || cpuf) && !m_stk[3]);
      ok = raw && (full_on || !m_off);
      if (full_on) m_off = 0; else if (ok) m_off = 1;
      nstk = m_stk & ~(clr_we ? clr_mask[5:0] : 6'd0);
      if (intrude) nstk[0] = 1;
      if (!therm_n) nstk[1] = 1;
      if (cpuf) nstk[2] = 1;
      if (wdt) nstk[3] = 1;
      if (sw) nstk[4] = 1;
      if (fvld && fdata == 8'hFF) nstk[5] = 1;
      go = (ok || m_pend) && (!m_send || ack);
      if (go) begin
        m_send = 1; m_pend = 0; m_seq = (m_seq + 1) % (1 << SEQ_W);
        m_stat = {gpio, nstk};
      end else begin
        if (ok) m_pend = 1;
        if (ack) m_send = 0;
      end
      m_stk = nstk; m_gpio = gpio; m_therm = therm_n;
    end
  end

  always @(posedge clk) begin
    #2;
    n_cmp++;
    if (send !== m_send || seq !== m_seq[SEQ_W-1:0] || status !== m_stat ||
        live !== {m_gpio, m_stk}) begin
      n_bad++;
      $display("FAIL %s t=%0t act send=%0b seq=%0d stat=%h live=%h exp send=%0b seq=%0d stat=%h live=%h",
               cur_req, $time, send, seq, status, live, m_send, m_seq, m_stat, {m_gpio, m_stk});
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt(); @(negedge clk); endtask
  task automatic do_ack(); ack = 1; nxt(); ack = 0; endtask
  task automatic clr_all(); clr_we = 1; clr_mask = 7'h7f; nxt(); clr_we = 0; clr_mask = 0; endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1;
    nxt();
    // R11 reset state
    chk(send == 0 && seq == 0, "R11", seq, 0);
    chk(live == 0 && status == 0, "R11", live, 0);

    cur_req = "R1";
    sw = 1; nxt(); sw = 0;
    chk(send == 1 && seq == 1, "R6", seq, 1);
    chk(status == 7'h10, "R1", status, 'h10);
    cur_req = "R5"; nxt(); chk(send == 1 && seq == 1, "R5", seq, 1);
    do_ack(); chk(send == 0, "R5", send, 0);

    cur_req = "R7";
    intrude = 1; fvld = 1; fdata = 8'hFF; nxt(); intrude = 0; fvld = 0;
    chk(seq == 2 && status == 7'h31, "R7", status, 'h31);
    do_ack();
    fvld = 1; fdata = 8'hFE; nxt(); fvld = 0; // R1 non-erased data ignored
    chk(send == 0 && seq == 2, "R1", seq, 2);
    clr_all(); chk(live == 0, "R4", live, 0);

    cur_req = "R2";
    therm_n = 0; repeat (3) nxt();
    chk(seq == 3 && live[1] == 1, "R2", seq, 3);
    do_ack(); nxt(); chk(send == 0 && seq == 3, "R2", seq, 3);
    therm_n = 1; nxt(); clr_all();
    chk(live == 0 && send == 0, "R2", live, 0);

    cur_req = "R3";
    gpio = 1; nxt(); chk(seq == 4 && status[6] == 1, "R3", seq, 4);
    do_ack();
    gpio = 0; nxt(); chk(seq == 5 && status[6] == 0, "R3", seq, 5);
    do_ack();

    cur_req = "R8";
    sw = 1; nxt(); sw = 0; nxt();
    intrude = 1; nxt(); intrude = 0; sw = 1; nxt(); sw = 0;
    chk(seq == 6 && send == 1, "R8", seq, 6);
    do_ack(); chk(seq == 7 && send == 1, "R8", seq, 7);
    do_ack(); chk(seq == 7 && send == 0, "R8", seq, 7);

    cur_req = "R10";
    clr_all();
    wdt = 1; nxt(); wdt = 0; chk(seq == 8, "R10", seq, 8);
    do_ack();
    wdt = 1; nxt(); wdt = 0; cpuf = 1; nxt(); cpuf = 0; nxt();
    chk(send == 0 && seq == 8 && live[2] == 1, "R10", seq, 8);
    clr_we = 1; clr_mask = 7'h08; nxt(); clr_we = 0; clr_mask = 0;
    cpuf = 1; nxt(); cpuf = 0; chk(seq == 9 && send == 1, "R10", seq, 9);
    do_ack();

    cur_req = "R9";
    full_on = 0; nxt();
    sw = 1; nxt(); sw = 0; chk(seq == 10, "R9", seq, 10);
    do_ack();
    sw = 1; nxt(); sw = 0; intrude = 1; nxt(); intrude = 0; nxt();
    chk(seq == 10 && send == 0 && live[0] == 1, "R9", seq, 10);
    full_on = 1; nxt();
    sw = 1; nxt(); sw = 0; chk(seq == 11, "R9", seq, 11);
    do_ack();

    cur_req = "R4";
    clr_we = 1; clr_mask = 7'h7f; intrude = 1; nxt(); clr_we = 0; clr_mask = 0; intrude = 0;
    chk(live == 7'h01 && seq == 12, "R4", live, 1);
    do_ack();

    cur_req = "R6";
    ack = 1; sw = 1;
    repeat (1 << SEQ_W) nxt();
    sw = 0; nxt(); ack = 0; nxt();
    chk(seq == 12 && send == 0, "R6", seq, 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule